// File: doc/BRIEF.md
# Economy Clock Divider with Switchback

This block sets the machine-cycle rate of a processor core and the peripherals that run with it. It counts oscillator clocks and emits a one-clock state-advance enable (`mc_tick`) once per machine cycle. A machine cycle lasts 4, 64 or 1024 clocks, chosen by software through a 2-bit rate code. The code in force is visible on `cdiv_cur`. A second control picks the clock source, crystal or internal RC. An interlock keeps the crystal from being selected before it reports that it is ready.

Rate and source writes do not act at once. An accepted write is held as a pending request and takes effect after one full machine cycle, always at a machine-cycle boundary. When switchback is enabled, serial activity or an acknowledged external interrupt pulls the rate straight back to divide-by-4 and drops any pending rate request. Rate writes are refused while a serial transfer is busy and switchback is on. Every reset source returns the block to divide-by-4 on the crystal.

The rate register is a three-state machine: RATE_D4, RATE_D64 and RATE_D1024. Its transitions are APPLY (a matured request, moving to the requested state), SNAPBACK (a switchback event, moving to RATE_D4) and RESET (moving to RATE_D4). Each pending request runs through PEND_IDLE, then PEND_WAIT (accepted, waiting for a boundary), then PEND_ARMED (one full machine cycle in progress). The edges are ACCEPT (to PEND_WAIT from any state), FIRST_EDGE (PEND_WAIT to PEND_ARMED), MATURE (PEND_ARMED to PEND_IDLE with apply) and FLUSH (to PEND_IDLE). The source register has two states, SRC_RC and SRC_XTAL, joined by APPLY and RESET.

Top module: `ecd_top`

## Requirements
- R1: Rate code 2'b01 gives a machine cycle of 4 clocks, 2'b10 gives 64 clocks and 2'b11 gives 1024 clocks. `mc_tick` is high for exactly one clock per machine cycle.
- R2: An accepted rate write leaves `cdiv_cur` unchanged across the first machine-cycle boundary after the write. The new code appears right after the second boundary.
- R3: A write of 2'b11 while the rate is 2'b10 is refused, and so is a write of 2'b10 while the rate is 2'b11. The rate never moves directly between the two slow codes.
- R4: A write of the reserved code 2'b00 is ignored, and `cdiv_cur` never shows 2'b00.
- R5: With `swb_en` high, any of the following makes `cdiv_cur` read 2'b01 in the next clock: `tx_buf_wr`, `xint_ack`, or `rx_start_fall` while `rx_en` is high. The same event discards any pending rate request, and the next `mc_tick` follows within 4 clocks.
- R6: `rx_start_fall` while `rx_en` is low causes no switchback. With `swb_en` low, no event causes a switchback.
- R7: With `swb_en` high, a rate write made while `tx_busy` or `rx_busy` is high is ignored. With `swb_en` low, busy flags do not block writes.
- R8: Low `rst_n` (asynchronous), or high `ext_rst` or `wdt_rst` (synchronous), sets `cdiv_cur` to 2'b01 and `src_xtal` to 1 and restarts the cycle count.
- R9: A source write of 1 (crystal) is refused while `xtal_ready` is 0. A source write of 0 (RC) is always accepted.
- R10: An accepted source write changes `src_xtal` only after the second machine-cycle boundary following the write.
- R11: Apart from switchback and reset, `cdiv_cur` changes only in the clock right after `mc_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on/fail reset, active low, asynchronous |
| ext_rst | input | 1 | External reset, active high, synchronous |
| wdt_rst | input | 1 | Watchdog reset, active high, synchronous |
| cdiv_wr | input | 1 | Rate code write strobe |
| cdiv_wdata | input | 2 | Rate code to write |
| swb_en | input | 1 | Switchback enable |
| rx_en | input | 1 | Serial reception enabled |
| rx_start_fall | input | 1 | One-clock pulse on a falling start-bit edge |
| tx_buf_wr | input | 1 | One-clock pulse on a serial buffer write |
| xint_ack | input | 1 | One-clock pulse on an acknowledged enabled external interrupt |
| tx_busy | input | 1 | Serial transmit in progress |
| rx_busy | input | 1 | Serial receive in progress |
| src_wr | input | 1 | Clock source write strobe |
| src_wdata | input | 1 | Source to write: 1 crystal, 0 RC |
| xtal_ready | input | 1 | Crystal warmed up and ready |
| mc_tick | output | 1 | State-advance enable, one clock per machine cycle |
| cdiv_cur | output | 2 | Rate code in force |
| src_xtal | output | 1 | Source in force: 1 crystal, 0 RC |

## Verification
The properties take the event inputs `rx_start_fall`, `tx_buf_wr` and `xint_ack` to be single-clock pulses. They also assume every input is synchronous to `clk`, so a switchback or reset in a given clock is fully visible at that edge. The stimulus drives every input on the falling edge and holds each pulse for exactly one clock. It never raises a write strobe in the same clock as a reset or switchback event, so the checked outcome of each case never rests on how simultaneous events are ordered.

// File: rtl/ecd_pkg.sv
package ecd_pkg;

    localparam logic [1:0] CODE_RSVD = 2'b00;
    localparam logic [1:0] CODE_D4   = 2'b01;
    localparam logic [1:0] CODE_D64  = 2'b10;
    localparam logic [1:0] CODE_D1K  = 2'b11;

    typedef enum logic [1:0] {
        RATE_D4    = 2'd0,
        RATE_D64   = 2'd1,
        RATE_D1024 = 2'd2
    } rate_e;

    typedef enum logic [1:0] {
        PEND_IDLE  = 2'd0,
        PEND_WAIT  = 2'd1,
        PEND_ARMED = 2'd2
    } pend_e;

    typedef enum logic {
        SRC_RC   = 1'b0,
        SRC_XTAL = 1'b1
    } src_e;

    function automatic logic [1:0] code_of(rate_e r);
        logic [1:0] c;
        unique case (r)
            RATE_D4:    c = CODE_D4;
            RATE_D64:   c = CODE_D64;
            RATE_D1024: c = CODE_D1K;
            default:    c = CODE_D4;
        endcase
        return c;
    endfunction

    function automatic rate_e rate_of(logic [1:0] c);
        rate_e r;
        unique case (c)
            CODE_D64: r = RATE_D64;
            CODE_D1K: r = RATE_D1024;
            default:  r = RATE_D4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ecd_mc_counter.sv
module ecd_mc_counter
    import ecd_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 64,
    parameter int DIV_SLOW = 1024
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_rst,
    input  rate_e rate,
    output logic  tick
);
    localparam int CNT_W = $clog2(DIV_SLOW);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    // Terminal count for the rate in force; a lowered rate ends the cycle early.
    always_comb begin
        unique case (rate)
            RATE_D4:    term = CNT_W'(DIV_FAST - 1);
            RATE_D64:   term = CNT_W'(DIV_MID - 1);
            RATE_D1024: term = CNT_W'(DIV_SLOW - 1);
            default:    term = CNT_W'(DIV_FAST - 1);
        endcase
    end

    assign tick = (cnt >= term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sync_rst || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ecd_delay_apply.sv
module ecd_delay_apply
    import ecd_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         req,
    input  logic [W-1:0] req_data,
    input  logic         tick,
    output logic         apply,
    output logic [W-1:0] apply_data
);
    pend_e        st_q;
    pend_e        st_nx;
    logic [W-1:0] held_q;

    // Next state: ACCEPT, FIRST_EDGE, MATURE, FLUSH
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PEND_IDLE: begin
                if (req) st_nx = PEND_WAIT;
            end
            PEND_WAIT: begin
                if (req)       st_nx = PEND_WAIT;
                else if (tick) st_nx = PEND_ARMED;
            end
            PEND_ARMED: begin
                if (req)       st_nx = PEND_WAIT;
                else if (tick) st_nx = PEND_IDLE;
            end
            default: st_nx = PEND_IDLE;
        endcase
        if (flush) st_nx = PEND_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= PEND_IDLE;
            held_q <= '0;
        end else begin
            st_q <= st_nx;
            if (req && !flush) held_q <= req_data;
        end
    end

    always_comb begin
        apply      = (st_q == PEND_ARMED) && tick && !req && !flush;
        apply_data = held_q;
    end

endmodule

// File: rtl/ecd_rate_ctl.sv
module ecd_rate_ctl
    import ecd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_rst,
    input  logic       wr,
    input  logic [1:0] wdata,
    input  logic       swb_en,
    input  logic       rx_en,
    input  logic       rx_start_fall,
    input  logic       tx_buf_wr,
    input  logic       xint_ack,
    input  logic       tx_busy,
    input  logic       rx_busy,
    input  logic       apply,
    input  logic [1:0] apply_code,
    output logic       accept,
    output logic       flush,
    output rate_e      rate
);
    rate_e rate_q;
    rate_e rate_nx;
    logic  snap;
    logic  locked;
    logic  slow_jump;

    always_comb begin
        snap      = swb_en && ((rx_en && rx_start_fall) || tx_buf_wr || xint_ack);
        locked    = swb_en && (tx_busy || rx_busy);
        slow_jump = ((rate_q == RATE_D64)   && (wdata == CODE_D1K)) ||
                    ((rate_q == RATE_D1024) && (wdata == CODE_D64));
        accept    = wr && (wdata != CODE_RSVD) && !locked && !slow_jump;
        flush     = snap || sync_rst;
    end

    // Transitions: RESET, SNAPBACK, APPLY
    always_comb begin
        rate_nx = rate_q;
        unique case (rate_q)
            RATE_D4, RATE_D64, RATE_D1024: begin
                if (sync_rst)   rate_nx = RATE_D4;
                else if (snap)  rate_nx = RATE_D4;
                else if (apply) rate_nx = rate_of(apply_code);
            end
            default: rate_nx = RATE_D4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_q <= RATE_D4;
        else        rate_q <= rate_nx;
    end

    assign rate = rate_q;

endmodule

// File: rtl/ecd_src_ctl.sv
module ecd_src_ctl
    import ecd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_rst,
    input  logic wr,
    input  logic wdata,
    input  logic xtal_ready,
    input  logic apply,
    input  logic apply_sel,
    output logic accept,
    output src_e src
);
    src_e src_q;
    src_e src_nx;

    assign accept = wr && (!wdata || xtal_ready);

    // Transitions: RESET, APPLY
    always_comb begin
        src_nx = src_q;
        unique case (src_q)
            SRC_RC, SRC_XTAL: begin
                if (sync_rst)   src_nx = SRC_XTAL;
                else if (apply) src_nx = apply_sel ? SRC_XTAL : SRC_RC;
            end
            default: src_nx = SRC_XTAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_XTAL;
        else        src_q <= src_nx;
    end

    assign src = src_q;

endmodule

// File: rtl/ecd_top.sv
module ecd_top
    import ecd_pkg::*;
#(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 64,
    parameter int DIV_SLOW = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst,
    input  logic       wdt_rst,
    input  logic       cdiv_wr,
    input  logic [1:0] cdiv_wdata,
    input  logic       swb_en,
    input  logic       rx_en,
    input  logic       rx_start_fall,
    input  logic       tx_buf_wr,
    input  logic       xint_ack,
    input  logic       tx_busy,
    input  logic       rx_busy,
    input  logic       src_wr,
    input  logic       src_wdata,
    input  logic       xtal_ready,
    output logic       mc_tick,
    output logic [1:0] cdiv_cur,
    output logic       src_xtal
);
    logic       sync_rst;
    logic       tick;
    rate_e      rate;
    logic       r_accept;
    logic       r_flush;
    logic       r_apply;
    logic [1:0] r_apply_code;
    logic       s_accept;
    logic       s_apply;
    logic [0:0] s_apply_sel;
    src_e       src;

    assign sync_rst = ext_rst || wdt_rst;

    ecd_mc_counter #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_rst (sync_rst),
        .rate     (rate),
        .tick     (tick)
    );

    ecd_rate_ctl rate_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_rst      (sync_rst),
        .wr            (cdiv_wr),
        .wdata         (cdiv_wdata),
        .swb_en        (swb_en),
        .rx_en         (rx_en),
        .rx_start_fall (rx_start_fall),
        .tx_buf_wr     (tx_buf_wr),
        .xint_ack      (xint_ack),
        .tx_busy       (tx_busy),
        .rx_busy       (rx_busy),
        .apply         (r_apply),
        .apply_code    (r_apply_code),
        .accept        (r_accept),
        .flush         (r_flush),
        .rate          (rate)
    );

    ecd_delay_apply #(.W(2)) rate_pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (r_flush),
        .req        (r_accept),
        .req_data   (cdiv_wdata),
        .tick       (tick),
        .apply      (r_apply),
        .apply_data (r_apply_code)
    );

    ecd_src_ctl src_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_rst   (sync_rst),
        .wr         (src_wr),
        .wdata      (src_wdata),
        .xtal_ready (xtal_ready),
        .apply      (s_apply),
        .apply_sel  (s_apply_sel[0]),
        .accept     (s_accept),
        .src        (src)
    );

    ecd_delay_apply #(.W(1)) src_pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (sync_rst),
        .req        (s_accept),
        .req_data   (src_wdata),
        .tick       (tick),
        .apply      (s_apply),
        .apply_data (s_apply_sel)
    );

    assign mc_tick  = tick;
    assign cdiv_cur = code_of(rate);
    assign src_xtal = (src == SRC_XTAL);

endmodule

// File: rtl/ecd_checker.sv
module ecd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_rst,
    input logic       wdt_rst,
    input logic       swb_en,
    input logic       rx_en,
    input logic       rx_start_fall,
    input logic       tx_buf_wr,
    input logic       xint_ack,
    input logic       mc_tick,
    input logic [1:0] cdiv_cur,
    input logic       src_xtal
);
    logic ev;
    assign ev = swb_en && ((rx_en && rx_start_fall) || tx_buf_wr || xint_ack);

    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> !mc_tick);

    assert_no_slow_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cdiv_cur == 2'b10) |=> (cdiv_cur != 2'b11));

    assert_no_slow_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cdiv_cur == 2'b11) |=> (cdiv_cur != 2'b10));

    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cdiv_cur != 2'b00);

    assert_snapback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (cdiv_cur == 2'b01));

    assert_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst || wdt_rst) |=> (cdiv_cur == 2'b01 && src_xtal && !mc_tick));

    assert_src_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !ext_rst && !wdt_rst) |=> $stable(src_xtal));

    assert_rate_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !ev && !ext_rst && !wdt_rst) |=> $stable(cdiv_cur));

endmodule

bind ecd_top ecd_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_rst       (ext_rst),
    .wdt_rst       (wdt_rst),
    .swb_en        (swb_en),
    .rx_en         (rx_en),
    .rx_start_fall (rx_start_fall),
    .tx_buf_wr     (tx_buf_wr),
    .xint_ack      (xint_ack),
    .mc_tick       (mc_tick),
    .cdiv_cur      (cdiv_cur),
    .src_xtal      (src_xtal)
);

// File: tb/ecd_top_tb_top.sv
module ecd_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0, wdt_rst = 1'b0;
    logic       cdiv_wr = 1'b0;
    logic [1:0] cdiv_wdata = 2'b00;
    logic       swb_en = 1'b0, rx_en = 1'b0, rx_start_fall = 1'b0;
    logic       tx_buf_wr = 1'b0, xint_ack = 1'b0;
    logic       tx_busy = 1'b0, rx_busy = 1'b0;
    logic       src_wr = 1'b0, src_wdata = 1'b0, xtal_ready = 1'b0;
    logic       mc_tick;
    logic [1:0] cdiv_cur;
    logic       src_xtal;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ecd_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
        .cdiv_wr(cdiv_wr), .cdiv_wdata(cdiv_wdata), .swb_en(swb_en),
        .rx_en(rx_en), .rx_start_fall(rx_start_fall), .tx_buf_wr(tx_buf_wr),
        .xint_ack(xint_ack), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .src_wr(src_wr), .src_wdata(src_wdata), .xtal_ready(xtal_ready),
        .mc_tick(mc_tick), .cdiv_cur(cdiv_cur), .src_xtal(src_xtal)
    );

    // {write code, code after first boundary, code after second boundary}
    localparam logic [5:0] VEC [9] = '{
        {2'b10, 2'b01, 2'b10},
        {2'b11, 2'b10, 2'b10},
        {2'b01, 2'b10, 2'b01},
        {2'b11, 2'b01, 2'b11},
        {2'b10, 2'b11, 2'b11},
        {2'b00, 2'b11, 2'b11},
        {2'b01, 2'b11, 2'b01},
        {2'b00, 2'b01, 2'b01},
        {2'b01, 2'b01, 2'b01}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_rate(input logic [1:0] d);
        @(negedge clk); cdiv_wr = 1'b1; cdiv_wdata = d;
        @(negedge clk); cdiv_wr = 1'b0;
    endtask

    task automatic wr_src(input logic d);
        @(negedge clk); src_wr = 1'b1; src_wdata = d;
        @(negedge clk); src_wr = 1'b0;
    endtask

    // Called at a falling edge; returns at the falling edge after the n-th tick edge.
    task automatic pass_ticks(input int n);
        int seen = 0;
        while (1) begin
            if (mc_tick) seen++;
            if (seen == n) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic tick_period(output int p);
        p = 0;
        do @(negedge clk); while (!mc_tick);
        do begin @(negedge clk); p++; end while (!mc_tick);
    endtask

    task automatic clocks_to_tick(output int c);
        c = 0;
        while (!mc_tick && c < 2000) begin @(negedge clk); c++; end
    endtask

    task automatic set_rate(input logic [1:0] d);
        if (cdiv_cur != 2'b01 && d != 2'b01) begin wr_rate(2'b01); pass_ticks(2); end
        wr_rate(d); pass_ticks(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        check("R8 reset rate", cdiv_cur, 1);
        check("R8 reset source", src_xtal, 1);
        check("R8 reset tick", mc_tick, 0);
        rst_n = 1'b1;

        tick_period(p); check("R1 period div4", p, 4);

        for (int i = 0; i < 9; i++) begin
            wr_rate(VEC[i][5:4]);
            pass_ticks(1);
            check($sformatf("R2/R3/R4 vec %0d first", i), cdiv_cur, int'(VEC[i][3:2]));
            pass_ticks(1);
            check($sformatf("R2/R3/R4 vec %0d second", i), cdiv_cur, int'(VEC[i][1:0]));
        end

        set_rate(2'b10); tick_period(p); check("R1 period div64", p, 64);
        set_rate(2'b11); tick_period(p); check("R1 period div1024", p, 1024);

        // Switchback by serial buffer write
        set_rate(2'b10); swb_en = 1'b1;
        @(negedge clk); tx_buf_wr = 1'b1; @(negedge clk); tx_buf_wr = 1'b0;
        check("R5 tx snap", cdiv_cur, 1);
        clocks_to_tick(p); check("R5 tick soon", int'(p <= 4), 1);

        // Interrupt acknowledge flushes a pending request
        wr_rate(2'b10); pass_ticks(1);
        @(negedge clk); xint_ack = 1'b1; @(negedge clk); xint_ack = 1'b0;
        pass_ticks(2); check("R5 flush pending", cdiv_cur, 1);

        // Receive edge qualified by rx_en
        swb_en = 1'b0; set_rate(2'b10); swb_en = 1'b1;
        @(negedge clk); rx_start_fall = 1'b1; @(negedge clk); rx_start_fall = 1'b0;
        check("R6 rx edge without rx_en", cdiv_cur, 2);
        rx_en = 1'b1;
        @(negedge clk); rx_start_fall = 1'b1; @(negedge clk); rx_start_fall = 1'b0;
        check("R5 rx edge snap", cdiv_cur, 1);

        // Switchback disabled
        swb_en = 1'b0; set_rate(2'b10);
        @(negedge clk); tx_buf_wr = 1'b1; xint_ack = 1'b1;
        @(negedge clk); tx_buf_wr = 1'b0; xint_ack = 1'b0;
        check("R6 no snap when disabled", cdiv_cur, 2);
        set_rate(2'b01);

        // Busy lockout
        swb_en = 1'b1; tx_busy = 1'b1;
        wr_rate(2'b10); pass_ticks(2); check("R7 tx busy lockout", cdiv_cur, 1);
        tx_busy = 1'b0; rx_busy = 1'b1;
        wr_rate(2'b11); pass_ticks(2); check("R7 rx busy lockout", cdiv_cur, 1);
        swb_en = 1'b0;
        wr_rate(2'b10); pass_ticks(2); check("R7 busy without switchback", cdiv_cur, 2);
        rx_busy = 1'b0;

        // Synchronous resets
        @(negedge clk); wdt_rst = 1'b1; @(negedge clk); wdt_rst = 1'b0;
        check("R8 watchdog reset", cdiv_cur, 1);
        set_rate(2'b11);
        @(negedge clk); ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
        check("R8 external reset", cdiv_cur, 1);

        // Source interlock and delay
        xtal_ready = 1'b0;
        wr_src(1'b0); pass_ticks(1); check("R10 source held first", src_xtal, 1);
        pass_ticks(1); check("R9 RC accepted", src_xtal, 0);
        wr_src(1'b1); pass_ticks(2); check("R9 crystal refused", src_xtal, 0);
        xtal_ready = 1'b1;
        wr_src(1'b1); pass_ticks(1); check("R10 crystal held first", src_xtal, 0);
        pass_ticks(1); check("R9 crystal accepted", src_xtal, 1);
        wr_src(1'b0); pass_ticks(2);
        @(negedge clk); ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
        check("R8 reset source", src_xtal, 1);

        // Power-on reset from a slow rate
        set_rate(2'b10);
        @(negedge clk); rst_n = 1'b0; #1;
        check("R8 power-on reset", cdiv_cur, 1);
        @(negedge clk); rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule